// File: doc/BRIEF.md
# Block Address Translation Array

This block turns a 32-bit effective address into a physical address by looking it up in a small array of block translation entries. Each entry maps one naturally aligned region, 128 KB to 256 MB in size, onto a physical region of the same size. A per-entry length mask sets the size. The lowest 17 address bits always pass through unchanged. Above them, the masked bits come from the effective address and the remaining bits come from the entry's physical block number.

The page translation runs beside this block and delivers its physical address and a valid flag at the same time as the effective address. The block picks one result from four possible sources. With translation turned off, the effective address passes straight through. A block hit wins over the page result. Without a block hit, a valid page result is used. If neither exists, the block raises a miss, which asks for a page table search.

The result is registered in a small result-state register with four named states: REAL, BLOCK, PAGE and MISS. The next state is chosen every cycle from the current inputs. REAL is taken when translation is disabled. BLOCK is taken on an enabled block hit. PAGE is taken on an enabled lookup with no hit and a valid page result. MISS is taken on an enabled lookup with neither. Any state can move to any other state on the next cycle. Reset enters REAL. Software loads entries through a single write port, one entry per cycle.

Top module: `bat_xlate`

## Requirements
- R1: Asynchronous active-low reset puts `pa_out` at 0 and `src_out` at REAL (0), clears `bat_hit` and `miss`, and invalidates every entry. An enabled lookup after reset with no valid page result therefore reports a miss.
- R2: When `xlate_en` is 0, the next result is `pa_out` equal to `ea`, `src_out` = REAL (0), and `bat_hit` and `miss` both 0. This holds whatever the entries contain.
- R3: An entry matches when `ea[31:17]` and the entry's block index agree on every bit whose mask bit is clear. The 11-bit length mask covers index bits 10:0, which are address bits 27:17. Index bits 14:11 are always compared.
- R4: On a block hit, bits 31:17 of `pa_out` are `(pblk & ~mask) | (ea[31:17] & mask)`, using the selected entry.
- R5: On a block hit, `pa_out[16:0]` equals `ea[16:0]`.
- R6: An entry takes part in a lookup only if its valid bit for the access type is set. The instruction valid bit applies when `acc_instr` is 1, and the data valid bit applies when it is 0.
- R7: When several entries match, the entry with the lowest index supplies the translation.
- R8: On an enabled block hit, the block result is used even when `page_valid` is 1. The result state is BLOCK (1) and `bat_hit` is 1.
- R9: On an enabled lookup with no block hit and `page_valid` at 1, `pa_out` equals `page_pa` and `src_out` = PAGE (2).
- R10: On an enabled lookup with no block hit and `page_valid` at 0, `miss` is 1, `src_out` = MISS (3) and `pa_out` is 0.
- R11: Results appear one clock after the inputs are sampled. A write to an entry first affects lookups in the cycle after the write, so a lookup in the same cycle as the write sees the old contents.
- R12: `bat_hit` is 1 exactly when `src_out` is BLOCK, and `miss` is 1 exactly when `src_out` is MISS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable |
| acc_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| ea | input | 32 | Effective address |
| page_pa | input | 32 | Physical address from the page translation path |
| page_valid | input | 1 | Page path result is valid |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 2 | Index of the entry to write |
| wr_eblk | input | 15 | Effective block index written (address bits 31:17) |
| wr_len | input | 11 | Block length mask written |
| wr_pblk | input | 15 | Physical block number written |
| wr_v_ins | input | 1 | Instruction-valid bit written |
| wr_v_dat | input | 1 | Data-valid bit written |
| pa_out | output | 32 | Final physical address |
| bat_hit | output | 1 | Result came from a block entry |
| src_out | output | 2 | Result source: 0 REAL, 1 BLOCK, 2 PAGE, 3 MISS |
| miss | output | 1 | No translation found; request a page table search |

## Verification
Every result is due exactly one clock edge after its inputs are sampled. The bench drives the inputs at a falling edge and compares all four outputs shortly after the next rising edge. A write to an entry affects only lookups that start after the write's own cycle. The bench model therefore computes the expected value from the entries as they stood before the write, and applies the write afterwards. The checker's properties use the same one-cycle offset: each one places its condition on the sampled inputs and checks the result on the following cycle.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 17;
    localparam int BIDX_W = PA_W - OFF_W;
    localparam int MASK_W = 11;

    typedef enum logic [1:0] {
        SRC_REAL  = 2'd0,
        SRC_BLOCK = 2'd1,
        SRC_PAGE  = 2'd2,
        SRC_MISS  = 2'd3
    } xsrc_e;

    typedef struct packed {
        logic [BIDX_W-1:0] eblk;
        logic [MASK_W-1:0] len;
        logic [BIDX_W-1:0] pblk;
        logic              v_ins;
        logic              v_dat;
    } bat_ent_t;

    function automatic logic [BIDX_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
        return {{(BIDX_W-MASK_W){1'b0}}, m};
    endfunction
endpackage

// File: rtl/bat_entry_file.sv
module bat_entry_file
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  bat_ent_t                  wr_data,
    output bat_ent_t [NUM_ENT-1:0]    ents
);
    // One register per entry; reset clears only the valid bits' meaning by zeroing all.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ents[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                ents[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/bat_match_unit.sv
module bat_match_unit
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  bat_ent_t [NUM_ENT-1:0] ents,
    input  logic [BIDX_W-1:0]      ea_blk,
    input  logic                   is_instr,
    output logic [NUM_ENT-1:0]     hit_vec
);
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        logic [BIDX_W-1:0] care;
        logic              addr_eq;
        logic              kind_ok;
        assign care    = ~widen_mask(ents[g].len);
        assign addr_eq = (((ea_blk ^ ents[g].eblk) & care) == '0);
        assign kind_ok = is_instr ? ents[g].v_ins : ents[g].v_dat;
        assign hit_vec[g] = addr_eq && kind_ok;
    end
endmodule

// File: rtl/bat_prio_select.sv
module bat_prio_select
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  bat_ent_t [NUM_ENT-1:0] ents,
    input  logic [NUM_ENT-1:0]     hit_vec,
    input  logic [BIDX_W-1:0]      ea_blk,
    output logic                   any_hit,
    output logic [BIDX_W-1:0]      blk_hi
);
    bat_ent_t          pick;
    logic [BIDX_W-1:0] wmask;

    // Scan from the top so the lowest matching index is the last one written.
    always_comb begin
        pick = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                pick = ents[i];
            end
        end
    end

    assign any_hit = |hit_vec;
    assign wmask   = widen_mask(pick.len);
    assign blk_hi  = (pick.pblk & ~wmask) | (ea_blk & wmask);
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic              acc_instr,
    input  logic [PA_W-1:0]   ea,
    input  logic [PA_W-1:0]   page_pa,
    input  logic              page_valid,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BIDX_W-1:0] wr_eblk,
    input  logic [MASK_W-1:0] wr_len,
    input  logic [BIDX_W-1:0] wr_pblk,
    input  logic              wr_v_ins,
    input  logic              wr_v_dat,
    output logic [PA_W-1:0]   pa_out,
    output logic              bat_hit,
    output logic [1:0]        src_out,
    output logic              miss
);
    bat_ent_t [NUM_ENT-1:0] ents;
    bat_ent_t               wr_data;
    logic [NUM_ENT-1:0]     hit_vec;
    logic                   any_hit;
    logic [BIDX_W-1:0]      blk_hi;
    logic [BIDX_W-1:0]      ea_blk;

    xsrc_e                  state_q, state_d;
    logic [PA_W-1:0]        pa_q, pa_d;

    assign ea_blk  = ea[PA_W-1:OFF_W];
    assign wr_data = '{eblk: wr_eblk, len: wr_len, pblk: wr_pblk,
                       v_ins: wr_v_ins, v_dat: wr_v_dat};

    bat_entry_file #(.NUM_ENT(NUM_ENT)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ents    (ents)
    );

    bat_match_unit #(.NUM_ENT(NUM_ENT)) u_match (
        .ents     (ents),
        .ea_blk   (ea_blk),
        .is_instr (acc_instr),
        .hit_vec  (hit_vec)
    );

    bat_prio_select #(.NUM_ENT(NUM_ENT)) u_prio (
        .ents    (ents),
        .hit_vec (hit_vec),
        .ea_blk  (ea_blk),
        .any_hit (any_hit),
        .blk_hi  (blk_hi)
    );

    // Next result state: every state is reachable from every state.
    always_comb begin
        if (!xlate_en) begin
            state_d = SRC_REAL;
        end else if (any_hit) begin
            state_d = SRC_BLOCK;
        end else if (page_valid) begin
            state_d = SRC_PAGE;
        end else begin
            state_d = SRC_MISS;
        end
    end

    always_comb begin
        unique case (state_d)
            SRC_REAL:  pa_d = ea;
            SRC_BLOCK: pa_d = {blk_hi, ea[OFF_W-1:0]};
            SRC_PAGE:  pa_d = page_pa;
            SRC_MISS:  pa_d = '0;
            default:   pa_d = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_REAL;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            pa_q    <= pa_d;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        pa_out  = pa_q;
        src_out = state_q;
        bat_hit = 1'b0;
        miss    = 1'b0;
        unique case (state_q)
            SRC_REAL:  ;
            SRC_BLOCK: bat_hit = 1'b1;
            SRC_PAGE:  ;
            SRC_MISS:  miss = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
    import bat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            xlate_en,
    input logic            page_valid,
    input logic [PA_W-1:0] ea,
    input logic [PA_W-1:0] page_pa,
    input logic [PA_W-1:0] pa_out,
    input logic [1:0]      src_out,
    input logic            bat_hit,
    input logic            miss
);
    assert_real_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en |=> (pa_out == $past(ea)) && (src_out == SRC_REAL) && !bat_hit && !miss);

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_en |=> (src_out != SRC_BLOCK) || (pa_out[OFF_W-1:0] == $past(ea[OFF_W-1:0])));

    assert_page_no_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_en && page_valid) |=> !miss && (src_out != SRC_REAL));

    assert_page_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_en && page_valid) |=> bat_hit || (pa_out == $past(page_pa)));

    assert_miss_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_en && !page_valid) |=> bat_hit || (miss && pa_out == '0));
endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xlate_en   (xlate_en),
    .page_valid (page_valid),
    .ea         (ea),
    .page_pa    (page_pa),
    .pa_out     (pa_out),
    .src_out    (src_out),
    .bat_hit    (bat_hit),
    .miss       (miss)
);

// File: tb/test_bat_xlate.sv
module test_bat_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0, acc_instr = 1'b0, page_valid = 1'b0;
    logic [31:0] ea = '0, page_pa = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [14:0] wr_eblk = '0, wr_pblk = '0;
    logic [10:0] wr_len = '0;
    logic        wr_v_ins = 1'b0, wr_v_dat = 1'b0;
    logic [31:0] pa_out;
    logic        bat_hit, miss;
    logic [1:0]  src_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [14:0] m_eblk [4];
    logic [10:0] m_len  [4];
    logic [14:0] m_pblk [4];
    logic        m_vi   [4];
    logic        m_vd   [4];

    always #5 clk = ~clk;

    bat_xlate i_bat_xlate (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .acc_instr(acc_instr),
        .ea(ea), .page_pa(page_pa), .page_valid(page_valid),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_eblk(wr_eblk), .wr_len(wr_len),
        .wr_pblk(wr_pblk), .wr_v_ins(wr_v_ins), .wr_v_dat(wr_v_dat),
        .pa_out(pa_out), .bat_hit(bat_hit), .src_out(src_out), .miss(miss)
    );

    // Reference result: {src, pa}
    function automatic logic [33:0] ref_result(input logic en, ins, input logic [31:0] a,
                                               input logic [31:0] ppa, input logic pv);
        if (!en) return {2'd0, a};
        for (int i = 0; i < 4; i++) begin
            logic [14:0] m;
            m = {4'b0, m_len[i]};
            if ((((a[31:17] ^ m_eblk[i]) & ~m) == 15'd0) && (ins ? m_vi[i] : m_vd[i]))
                return {2'd1, (m_pblk[i] & ~m) | (a[31:17] & m), a[16:0]};
        end
        if (pv) return {2'd2, ppa};
        return {2'd3, 32'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] exp_pa, input logic [1:0] exp_src);
        logic exp_hit, exp_miss;
        exp_hit  = (exp_src == 2'd1);
        exp_miss = (exp_src == 2'd3);
        checks++;
        if (pa_out !== exp_pa || src_out !== exp_src || bat_hit !== exp_hit || miss !== exp_miss) begin
            failures++;
            $display("FAIL %s: pa=%h src=%0d hit=%b miss=%b expected pa=%h src=%0d hit=%b miss=%b",
                     tag, pa_out, src_out, bat_hit, miss, exp_pa, exp_src, exp_hit, exp_miss);
        end
    endtask

    // Called at a falling edge; drives, waits one rising edge, checks.
    task automatic step(input string tag, input logic en, ins, input logic [31:0] a,
                        input logic [31:0] ppa, input logic pv,
                        input logic we, input logic [1:0] ws, input logic [14:0] eb,
                        input logic [10:0] ln, input logic [14:0] pb, input logic vi, vd);
        logic [33:0] e;
        xlate_en = en; acc_instr = ins; ea = a; page_pa = ppa; page_valid = pv;
        wr_en = we; wr_sel = ws; wr_eblk = eb; wr_len = ln; wr_pblk = pb;
        wr_v_ins = vi; wr_v_dat = vd;
        e = ref_result(en, ins, a, ppa, pv);
        if (we) begin
            m_eblk[ws] = eb; m_len[ws] = ln; m_pblk[ws] = pb; m_vi[ws] = vi; m_vd[ws] = vd;
        end
        @(posedge clk);
        #1;
        check(tag, e[31:0], e[33:32]);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string tag, input logic en, ins, input logic [31:0] a,
                        input logic [31:0] ppa, input logic pv);
        step(tag, en, ins, a, ppa, pv, 1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) begin
            m_eblk[i] = '0; m_len[i] = '0; m_pblk[i] = '0; m_vi[i] = 0; m_vd[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset outputs", 32'd0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R10: entries empty after reset, no page -> miss
        look("R1 R10 empty table miss", 1, 0, 32'h0246_8ace, 32'h1111_2222, 0);
        // R2: disabled passes address
        look("R2 R12 disabled passthru", 0, 1, 32'hdead_beef, 32'h1111_2222, 1);
        // R11: write entry0 and look it up in the same cycle -> old contents
        step("R11 same-cycle write unseen", 1, 0, {15'h1234, 17'h1abcd}, 32'h0, 0,
             1, 2'd0, 15'h1234, 11'h000, 15'h0055, 0, 1);
        look("R3 R4 R5 R11 block hit 128KB", 1, 0, {15'h1234, 17'h1abcd}, 32'h0, 0);
        look("R6 instr ignores data-only entry", 1, 1, {15'h1234, 17'h00001}, 32'h0, 0);
        look("R3 R9 index mismatch uses page", 1, 0, {15'h1235, 17'h00010}, 32'hcafe_0000, 1);
        // Entry1: largest block covering entry0's region
        step("R12 write while disabled", 0, 0, 32'h0000_1000, 32'h0, 0,
             1, 2'd1, 15'h1000, 11'h7ff, 15'h2000, 1, 1);
        look("R7 lowest entry wins", 1, 0, {15'h1234, 17'h0f0f0}, 32'h0, 0);
        look("R4 R6 instr picks masked entry", 1, 1, {15'h1234, 17'h0f0f0}, 32'h0, 0);
        look("R8 block beats page", 1, 1, {15'h17ff, 17'h1ffff}, 32'h5555_aaaa, 1);
        look("R3 upper index bits compared", 1, 1, {15'h0fff, 17'h0}, 32'h0, 0);
        look("R2 disabled with hit present", 0, 0, {15'h1234, 17'h1abcd}, 32'h0, 1);

        // Random mix of writes and lookups
        for (int n = 0; n < 600; n++) begin
            logic we, ins, en, pv;
            logic [1:0]  ws;
            logic [14:0] eb, pb;
            logic [10:0] ln;
            logic [31:0] a;
            int k, pick;
            we  = ($urandom % 4) == 0;
            ws  = 2'($urandom);
            k   = $urandom % 12;
            ln  = 11'((32'd1 << k) - 1);
            eb  = 15'($urandom);
            pb  = 15'($urandom);
            ins = 1'($urandom);
            en  = ($urandom % 8) != 0;
            pv  = 1'($urandom);
            a   = $urandom;
            pick = $urandom % 4;
            if ($urandom % 2) a[31:17] = m_eblk[pick] ^ (15'($urandom) & {4'b0, m_len[pick]});
            step("R3 R4 R6 R7 R9 R10 R11 random", en, ins, a, $urandom, pv,
                 we, ws, eb, ln, pb, 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule